// File: doc/BRIEF.md
# Page Frame Index Lookup

This block translates a storage page number into the index of the physical frame that backs it. It also reports the page's status as a two-bit condition code. A lookup request carries a 32-bit operand address and the present contents of the destination register. The block extracts the page number from a fixed field of the address and compares it against a page-capacity limit that software can set at run time. It then reads two on-chip tables: one holds a two-bit status for each page and the other holds a frame index for each page.

For a page that is addressable or connected, the block returns the frame index, zero-extended to 32 bits, and asserts a write enable for the destination register. For a page that is disconnected, and for a page number outside the capacity limit, no write enable is raised and the destination value passes through unchanged. A configuration port loads table entries, the page-capacity count and the frame-capacity count. Writes on this port are refused while a lookup is being presented.

Top module: `pfi_lookup`

## Requirements
- R1: The page number is `req_addr[23:11]` (bit 31 is the most significant bit). Address bits 31:24 and 10:0 have no effect on any result.
- R2: If the page number is greater than or equal to the page-capacity count, or greater than or equal to the table depth, the block gives `resp_cc` = 3 and `resp_wen` = 0, and `resp_data` equals the `req_dst` of that request.
- R3: A page with status code 2'b00 (addressable) gives `resp_cc` = 0 and `resp_wen` = 1. `resp_data` holds the stored frame index in bits FIDX_W-1:0, and all bits above it are zero.
- R4: A page with status code 2'b01 (connected) gives `resp_cc` = 1, `resp_wen` = 1, and the zero-extended frame index.
- R5: A page with status code 2'b10 or 2'b11 (disconnected) gives `resp_cc` = 2 and `resp_wen` = 0, and `resp_data` equals `req_dst`.
- R6: `resp_done` is high in exactly the cycle after each cycle with `req_valid` high. `resp_cc`, `resp_wen` and `resp_data` are valid together with it. `resp_wen` is never high without `resp_done`. Back-to-back requests are accepted on every cycle.
- R7: Reset (synchronous, active high) clears `resp_done` and `resp_wen` and sets both capacity counts to zero, so every lookup after reset returns code 3 until the counts are loaded.
- R8: A configuration write presented in the same cycle as `req_valid` is dropped entirely. This applies to table entries and to both counts.
- R9: A table-entry write (`cfg_sel` = 0) to a page at or above the page-capacity count, or at or above the table depth, leaves that entry unchanged.
- R10: A table-entry write with status 2'b00 or 2'b01 and a frame index greater than or equal to the frame-capacity count is dropped. Disconnected entries accept any index.
- R11: `cfg_sel` = 1 loads the page-capacity count and `cfg_sel` = 2 loads the frame-capacity count from `cfg_count`. The new value governs requests and entry writes from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 table entry, 1 page-capacity count, 2 frame-capacity count |
| cfg_page | input | 13 | Page addressed by an entry write |
| cfg_state | input | 2 | Status code for an entry write |
| cfg_fidx | input | FIDX_W | Frame index for an entry write |
| cfg_count | input | CNT_W | Value for a count write |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 32 | Operand address |
| req_dst | input | 32 | Present destination register value |
| resp_done | output | 1 | Result valid |
| resp_cc | output | 2 | Condition code 0..3 |
| resp_wen | output | 1 | Destination write enable |
| resp_data | output | 32 | Destination value after the lookup |

## Verification
A configuration write and a lookup can arrive in the same cycle. The bench provokes this by raising `cfg_we` alongside `req_valid` for an entry write and for count writes. It then judges the outcome with ordinary lookups in later cycles, which must still return the old entry and the old limits. A behavioural model runs alongside the design and is compared on every clock, so each such collision is also checked against that model.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
  localparam int PAGE_W   = 13;
  localparam int PAGE_LSB = 11;
  localparam int CAP_W    = PAGE_W + 1;

  typedef enum logic [1:0] {
    CFG_ENTRY = 2'd0,
    CFG_PCAP  = 2'd1,
    CFG_FCAP  = 2'd2
  } cfg_sel_e;

  typedef enum logic [1:0] {
    PG_ADDRESSABLE = 2'b00,
    PG_CONNECTED   = 2'b01,
    PG_DISCONN     = 2'b10,
    PG_DISCONN_ALT = 2'b11
  } pg_state_e;

  localparam logic [1:0] CC_ADDR  = 2'd0;
  localparam logic [1:0] CC_CONN  = 2'd1;
  localparam logic [1:0] CC_DISC  = 2'd2;
  localparam logic [1:0] CC_RANGE = 2'd3;
endpackage

// File: rtl/pfi_table.sv
module pfi_table #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 12,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pfi_cfg.sv
module pfi_cfg
  import pfi_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int FIDX_W = 12,
  parameter int CNT_W  = 16,
  localparam int FCAP_W = FIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic [1:0]        cfg_state,
  input  logic [FIDX_W-1:0] cfg_fidx,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              req_valid,
  output logic [CAP_W-1:0]  page_cap,
  output logic              entry_we
);
  localparam logic [CAP_W-1:0] DEPTH_C = CAP_W'(DEPTH);

  logic [FCAP_W-1:0] frame_cap;
  logic              wr_ok;
  logic              page_ok;
  logic              fidx_ok;
  logic              unused_cnt;

  assign wr_ok   = cfg_we && !req_valid;
  assign page_ok = ({1'b0, cfg_page} < page_cap) && ({1'b0, cfg_page} < DEPTH_C);
  assign fidx_ok = cfg_state[1] || ({1'b0, cfg_fidx} < frame_cap);
  assign entry_we = wr_ok && (cfg_sel == CFG_ENTRY) && page_ok && fidx_ok;
  assign unused_cnt = ^cfg_count[CNT_W-1:CAP_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      page_cap  <= '0;
      frame_cap <= '0;
    end else if (wr_ok) begin
      if (cfg_sel == CFG_PCAP) page_cap  <= cfg_count[CAP_W-1:0];
      if (cfg_sel == CFG_FCAP) frame_cap <= cfg_count[FCAP_W-1:0];
    end
  end

  // R8: counts frozen while a lookup is presented
  a_r8_caps_frozen: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> ($stable(page_cap) && $stable(frame_cap)));
  // R10: an accepted live entry always carries an in-range index
  a_r10_fidx_in_range: assert property (@(posedge clk) disable iff (rst)
    (entry_we && !cfg_state[1]) |-> ({1'b0, cfg_fidx} < frame_cap));
  // R9: accepted entry lies below the page limit
  a_r9_page_in_range: assert property (@(posedge clk) disable iff (rst)
    entry_we |-> ({1'b0, cfg_page} < page_cap));
endmodule

// File: rtl/pfi_classify.sv
module pfi_classify
  import pfi_pkg::*;
#(
  parameter int FIDX_W = 12
) (
  input  logic              valid,
  input  logic              in_range,
  input  logic [1:0]        state,
  input  logic [FIDX_W-1:0] fidx,
  input  logic [31:0]       dst,
  output logic [1:0]        cc,
  output logic              wen,
  output logic [31:0]       data
);
  always_comb begin
    if (!in_range) begin
      cc = CC_RANGE;
    end else begin
      unique case (state)
        PG_ADDRESSABLE: cc = CC_ADDR;
        PG_CONNECTED:   cc = CC_CONN;
        default:        cc = CC_DISC;
      endcase
    end
    wen  = valid && in_range && !state[1];
    data = wen ? {{(32-FIDX_W){1'b0}}, fidx} : dst;
  end
endmodule

// File: rtl/pfi_lookup.sv
module pfi_lookup
  import pfi_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int FIDX_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [12:0]       cfg_page,
  input  logic [1:0]        cfg_state,
  input  logic [FIDX_W-1:0] cfg_fidx,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_dst,
  output logic              resp_done,
  output logic [1:0]        resp_cc,
  output logic              resp_wen,
  output logic [31:0]       resp_data
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CAP_W-1:0] DEPTH_C = CAP_W'(DEPTH);

  logic [PAGE_W-1:0] page;
  logic [CAP_W-1:0]  page_cap;
  logic              entry_we;
  logic              in_range;
  logic              v_q;
  logic              in_range_q;
  logic [31:0]       dst_q;
  logic [1:0]        st_rd;
  logic [FIDX_W-1:0] fx_rd;
  logic              unused_bits;

  assign page     = req_addr[PAGE_LSB +: PAGE_W];
  assign in_range = ({1'b0, page} < page_cap) && ({1'b0, page} < DEPTH_C);
  assign unused_bits = ^{req_addr[31:PAGE_LSB+PAGE_W], req_addr[PAGE_LSB-1:0],
                         cfg_page[PAGE_W-1:AW], page[PAGE_W-1:AW]};

  pfi_cfg #(.DEPTH(DEPTH), .FIDX_W(FIDX_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_page(cfg_page), .cfg_state(cfg_state), .cfg_fidx(cfg_fidx),
    .cfg_count(cfg_count), .req_valid(req_valid),
    .page_cap(page_cap), .entry_we(entry_we)
  );

  pfi_table #(.DEPTH(DEPTH), .WIDTH(2)) u_state_tbl (
    .clk(clk), .we(entry_we), .waddr(cfg_page[AW-1:0]), .wdata(cfg_state),
    .raddr(page[AW-1:0]), .rdata(st_rd)
  );

  pfi_table #(.DEPTH(DEPTH), .WIDTH(FIDX_W)) u_fidx_tbl (
    .clk(clk), .we(entry_we), .waddr(cfg_page[AW-1:0]), .wdata(cfg_fidx),
    .raddr(page[AW-1:0]), .rdata(fx_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q        <= 1'b0;
      in_range_q <= 1'b0;
      dst_q      <= '0;
    end else begin
      v_q        <= req_valid;
      in_range_q <= in_range;
      dst_q      <= req_dst;
    end
  end

  pfi_classify #(.FIDX_W(FIDX_W)) u_cls (
    .valid(v_q), .in_range(in_range_q), .state(st_rd), .fidx(fx_rd),
    .dst(dst_q), .cc(resp_cc), .wen(resp_wen), .data(resp_data)
  );

  assign resp_done = v_q;

  // R6: one-cycle response
  a_r6_done_after_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_done);
  a_r6_no_spurious_done: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !resp_done);
  a_r6_wen_with_done: assert property (@(posedge clk) disable iff (rst)
    resp_wen |-> resp_done);
  // R2/R5: codes 2 and 3 never write
  a_r2_r5_no_write_high_cc: assert property (@(posedge clk) disable iff (rst)
    (resp_done && resp_cc[1]) |-> !resp_wen);
  // R2/R5: unchanged destination passes through
  a_r5_dst_passthrough: assert property (@(posedge clk) disable iff (rst)
    (resp_done && !resp_wen) |-> (resp_data == $past(req_dst)));
  // R3: written value is zero-extended
  a_r3_zero_ext: assert property (@(posedge clk) disable iff (rst)
    resp_wen |-> (resp_data[31:FIDX_W] == '0));
endmodule

// File: tb/pfi_lookup_tb_top.sv
module pfi_lookup_tb_top;
  localparam int DEPTH  = 256;
  localparam int FIDX_W = 12;
  localparam int CNT_W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [12:0] cfg_page = '0;
  logic [1:0] cfg_state = '0;
  logic [FIDX_W-1:0] cfg_fidx = '0;
  logic [CNT_W-1:0] cfg_count = '0;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_dst = '0;
  logic resp_done;
  logic [1:0] resp_cc;
  logic resp_wen;
  logic [31:0] resp_data;

  always #2 clk = ~clk;

  pfi_lookup #(.DEPTH(DEPTH), .FIDX_W(FIDX_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_page(cfg_page), .cfg_state(cfg_state), .cfg_fidx(cfg_fidx),
    .cfg_count(cfg_count), .req_valid(req_valid), .req_addr(req_addr),
    .req_dst(req_dst), .resp_done(resp_done), .resp_cc(resp_cc),
    .resp_wen(resp_wen), .resp_data(resp_data)
  );

  // reference model state
  int m_st [DEPTH];
  int m_fx [DEPTH];
  int m_pcap = 0;
  int m_fcap = 0;
  bit e_done = 0;
  bit e_wen = 0;
  int e_cc = 0;
  logic [31:0] e_data = '0;
  bit chk_en = 0;
  string phase = "R7";
  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always @(posedge clk) begin
    int pg;
    chk_en = 1;
    if (rst) begin
      e_done = 0; e_wen = 0; m_pcap = 0; m_fcap = 0;
    end else begin
      e_done = req_valid;
      e_wen = 0;
      if (req_valid) begin
        pg = int'(req_addr[23:11]);
        e_data = req_dst;
        if (pg >= m_pcap || pg >= DEPTH) e_cc = 3;
        else if (m_st[pg] == 0 || m_st[pg] == 1) begin
          e_cc = m_st[pg]; e_wen = 1; e_data = 32'(m_fx[pg]);
        end else e_cc = 2;
      end
      if (cfg_we && !req_valid) begin
        if (cfg_sel == 2'd1) m_pcap = int'(cfg_count);
        else if (cfg_sel == 2'd2) m_fcap = int'(cfg_count);
        else if (cfg_sel == 2'd0) begin
          pg = int'(cfg_page);
          if (pg < m_pcap && pg < DEPTH &&
              (cfg_state >= 2 || int'(cfg_fidx) < m_fcap)) begin
            m_st[pg] = int'(cfg_state); m_fx[pg] = int'(cfg_fidx);
          end
        end
      end
    end
  end

  task automatic report(string what, logic [31:0] act, logic [31:0] exp);
    n_bad++;
    $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", phase, what, act, exp, cyc);
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      n_cmp++;
      if (resp_done !== e_done) report("done (R6)", 32'(resp_done), 32'(e_done));
      else if (resp_wen !== e_wen) report("wen", 32'(resp_wen), 32'(e_wen));
      else if (e_done && resp_cc !== 2'(e_cc)) report("cc", 32'(resp_cc), 32'(e_cc));
      else if (e_done && resp_data !== e_data) report("data", resp_data, e_data);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
    cfg_we = 0; req_valid = 0;
  endtask

  task automatic set_cnt(logic [1:0] sel, int val);
    cfg_we = 1; cfg_sel = sel; cfg_count = CNT_W'(val);
    step();
  endtask

  task automatic wr_entry(int pg, int st, int fx);
    cfg_we = 1; cfg_sel = 2'd0; cfg_page = 13'(pg);
    cfg_state = 2'(st); cfg_fidx = FIDX_W'(fx);
    step();
  endtask

  function automatic logic [31:0] mk_addr(int pg);
    logic [31:0] r = $urandom;
    r[23:11] = 13'(pg);
    return r;
  endfunction

  task automatic look(int pg);
    req_valid = 1; req_addr = mk_addr(pg); req_dst = $urandom;
    step();
  endtask

  initial begin
    #1;
    repeat (4) step();
    rst = 0;
    phase = "R7";
    look(0); look(5); step();
    phase = "R11";
    set_cnt(2'd1, 256);
    set_cnt(2'd2, 3000);
    for (int i = 0; i < DEPTH; i++) wr_entry(i, i % 4, (i * 37) % 3000);
    phase = "R3"; for (int i = 0; i < 40; i += 4) look(i);
    phase = "R4"; for (int i = 1; i < 40; i += 4) look(i);
    phase = "R5"; for (int i = 2; i < 40; i++) look(i);
    phase = "R1"; for (int k = 0; k < 30; k++) look(k * 7 % DEPTH);
    phase = "R6";
    for (int k = 0; k < 20; k++) begin look(k); if (k % 3 == 0) step(); end
    phase = "R10";
    wr_entry(4, 0, 3000); wr_entry(5, 1, 4000); wr_entry(6, 2, 3500);
    look(4); look(5); look(6);
    phase = "R9";
    set_cnt(2'd1, 200);
    wr_entry(220, 1, 9); wr_entry(199, 0, 11);
    set_cnt(2'd1, 256);
    look(220); look(199);
    phase = "R2";
    set_cnt(2'd1, 100);
    look(99); look(100); look(150);
    set_cnt(2'd1, 8192);
    look(255); look(256); look(5000); look(8191);
    set_cnt(2'd1, 256);
    phase = "R8";
    cfg_we = 1; cfg_sel = 2'd0; cfg_page = 13'd12; cfg_state = 2'd1; cfg_fidx = 12'd77;
    look(20);
    cfg_we = 1; cfg_sel = 2'd1; cfg_count = 16'd10;
    look(30);
    cfg_we = 1; cfg_sel = 2'd2; cfg_count = 16'd1;
    look(40);
    look(12); look(30);
    wr_entry(13, 0, 2999);
    look(13);
    phase = "R11";
    set_cnt(2'd2, 50);
    wr_entry(14, 0, 60); wr_entry(15, 1, 49);
    look(14); look(15);
    set_cnt(2'd1, 0);
    look(0); look(1);
    phase = "R7";
    rst = 1; step(); step(); rst = 0;
    look(3); step(); step();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule